// File: doc/BRIEF.md
# Low-Power Entry Service Sequencer

This block runs the service that moves a device into a deep freeze state and back out. A requester issues a one-cycle request. The request carries a four-bit mask that picks which power domains to shut down. Before any domain is touched, the sequencer offers a fixed announcement byte (8'hE0) to an outbound byte FIFO that feeds the processor. It waits for as long as the FIFO needs to take that byte. It then issues one cycle of power-down strobes for the selected domains, holds those domains down and sits in the frozen state. A wake pulse releases every held domain and returns the block to idle.

Only one service runs at a time. A request that arrives while a service is in progress is refused at once with a one-cycle reject pulse, and the running service carries on unchanged. A retention selection is captured along with each request. Suspend keeps SRAM contents through the freeze. Sleep drops them, and the block then marks the exit so that downstream logic treats SRAM data as invalid.

Top module: `lpf_seq`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to idle; every output is 0 after that edge.
- R2: A request accepted in idle makes fifo_vld_o high from the next cycle, with fifo_byte_o = 8'hE0. This lasts until a cycle in which fifo_rdy_i is high. pd_strobe_o stays 0 throughout.
- R3: A request while busy_o is high gives req_abort_o = 1 in the following cycle only. The running service keeps its original mask and sequence. A request accepted from idle gives no reject pulse.
- R4: Mask bit 0 selects the fabric, bit 1 memory bank 0, bit 2 memory bank 1 and bit 3 the PLL. In the cycle after the FIFO takes the byte, pd_strobe_o equals the captured mask for exactly one cycle.
- R5: From the cycle after the strobe, frozen_o is high and pd_hold_o equals the captured mask. Unselected domains are never held.
- R6: A wake_i pulse in the frozen state gives exit_o = 1 for one cycle, with pd_hold_o still held. In the cycle after that the block is idle, with busy_o and pd_hold_o at 0.
- R7: retain_i is captured with the request (1 = suspend, 0 = sleep). sram_keep_o equals the captured value during the strobe and frozen cycles. sram_invalid_o pulses together with exit_o only when sleep was captured.
- R8: wake_i outside the frozen state and fifo_rdy_i outside the notify state have no effect on state or outputs.
- R9: A reset during a service clears the freeze at the next edge. frozen_o, busy_o and pd_hold_o go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | One-cycle service request |
| req_mask_i | input | 4 | Domain select (bit0 fabric, bit1 mem0, bit2 mem1, bit3 PLL) |
| retain_i | input | 1 | SRAM state while frozen: 1 suspend, 0 sleep |
| fifo_rdy_i | input | 1 | Outbound FIFO can take a byte |
| wake_i | input | 1 | Wake event pulse |
| fifo_vld_o | output | 1 | Announcement byte offered |
| fifo_byte_o | output | 8 | Announcement byte value |
| pd_strobe_o | output | 4 | One-cycle power-down strobe per domain |
| pd_hold_o | output | 4 | Held power-down per domain |
| req_abort_o | output | 1 | Rejected request pulse |
| busy_o | output | 1 | A service is in progress |
| frozen_o | output | 1 | Frozen state |
| exit_o | output | 1 | One-cycle freeze exit indication |
| sram_keep_o | output | 1 | SRAM contents are being kept |
| sram_invalid_o | output | 1 | SRAM contents lost at this exit |

## Verification
The hardest case to reach is a second request that lands inside a stalled notify phase or the frozen state, with a different mask. It must be refused without disturbing the strobes and holds of the first service. To reach it, the stimulus holds fifo_rdy_i low for a varying number of cycles and fires the conflicting request with the inverted mask. It then checks that the strobe still carries the original mask. This runs across every mask value and both retention modes. During the stalls and the frozen wait, the stimulus also drives the handshake and wake inputs at the wrong moments.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

    localparam int unsigned LPF_DOMAINS = 4;
    localparam int unsigned LPF_BYTE_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_NOTIFY = 3'd1,
        ST_PDOWN  = 3'd2,
        ST_FROZEN = 3'd3,
        ST_WAKE   = 3'd4
    } lpf_state_e;

endpackage

// File: rtl/lpf_fsm.sv
module lpf_fsm
    import lpf_pkg::*;
#(
    parameter int unsigned N_DOM = LPF_DOMAINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [N_DOM-1:0] mask_i,
    input  logic             retain_i,
    input  logic             fifo_rdy_i,
    input  logic             wake_i,
    output lpf_state_e       state_o,
    output logic [N_DOM-1:0] mask_o,
    output logic             retain_o
);

    typedef struct packed {
        lpf_state_e       st;
        logic [N_DOM-1:0] mask;
        logic             retain;
    } fsm_regs_t;

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    regs_d.st     = ST_NOTIFY;
                    regs_d.mask   = mask_i;
                    regs_d.retain = retain_i;
                end
            end
            ST_NOTIFY: begin
                if (fifo_rdy_i) begin
                    regs_d.st = ST_PDOWN;
                end
            end
            ST_PDOWN: begin
                regs_d.st = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (wake_i) begin
                    regs_d.st = ST_WAKE;
                end
            end
            ST_WAKE: begin
                regs_d.st = ST_IDLE;
            end
            default: begin
                regs_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, mask: '0, retain: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o  = regs_q.st;
    assign mask_o   = regs_q.mask;
    assign retain_o = regs_q.retain;

    AST_BUSY_REQ_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && regs_q.st != ST_IDLE) |=> (mask_o == $past(mask_o) && retain_o == $past(retain_o)))
        else $error("busy request altered captured options"); // R3

    AST_WAKE_ONLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st != ST_FROZEN && regs_q.st != ST_PDOWN) |=> (regs_q.st != ST_WAKE))
        else $error("wake state entered from wrong state"); // R8

endmodule

// File: rtl/lpf_domain_bank.sv
module lpf_domain_bank
    import lpf_pkg::*;
#(
    parameter int unsigned N_DOM = LPF_DOMAINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             release_i,
    input  logic [N_DOM-1:0] mask_i,
    output logic [N_DOM-1:0] strobe_o,
    output logic [N_DOM-1:0] hold_o
);

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        logic hold_d, hold_q;

        always_comb begin
            hold_d = hold_q;
            if (release_i) begin
                hold_d = 1'b0;
            end else if (fire_i && mask_i[g]) begin
                hold_d = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q <= 1'b0;
            end else begin
                hold_q <= hold_d;
            end
        end

        assign strobe_o[g] = fire_i & mask_i[g];
        assign hold_o[g]   = hold_q;

        AST_HOLD_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            hold_q |-> mask_i[g])
            else $error("unselected domain held"); // R5
    end

endmodule

// File: rtl/lpf_abort_gate.sv
module lpf_abort_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic busy_i,
    output logic abort_o
);

    logic abort_d, abort_q;

    always_comb begin
        abort_d = req_i & busy_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else begin
            abort_q <= abort_d;
        end
    end

    assign abort_o = abort_q;

endmodule

// File: rtl/lpf_seq.sv
module lpf_seq
    import lpf_pkg::*;
#(
    parameter int unsigned            N_DOM       = LPF_DOMAINS,
    parameter int unsigned            BYTE_W      = LPF_BYTE_W,
    parameter logic [BYTE_W-1:0]      NOTIFY_CODE = 8'hE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [N_DOM-1:0]  req_mask_i,
    input  logic              retain_i,
    input  logic              fifo_rdy_i,
    input  logic              wake_i,
    output logic              fifo_vld_o,
    output logic [BYTE_W-1:0] fifo_byte_o,
    output logic [N_DOM-1:0]  pd_strobe_o,
    output logic [N_DOM-1:0]  pd_hold_o,
    output logic              req_abort_o,
    output logic              busy_o,
    output logic              frozen_o,
    output logic              exit_o,
    output logic              sram_keep_o,
    output logic              sram_invalid_o
);

    lpf_state_e       state;
    logic [N_DOM-1:0] cap_mask;
    logic             cap_retain;

    lpf_fsm #(.N_DOM(N_DOM)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .mask_i     (req_mask_i),
        .retain_i   (retain_i),
        .fifo_rdy_i (fifo_rdy_i),
        .wake_i     (wake_i),
        .state_o    (state),
        .mask_o     (cap_mask),
        .retain_o   (cap_retain)
    );

    lpf_domain_bank #(.N_DOM(N_DOM)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (state == ST_PDOWN),
        .release_i (state == ST_WAKE),
        .mask_i    (cap_mask),
        .strobe_o  (pd_strobe_o),
        .hold_o    (pd_hold_o)
    );

    lpf_abort_gate abort_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .busy_i  (busy_o),
        .abort_o (req_abort_o)
    );

    assign busy_o         = (state != ST_IDLE);
    assign fifo_vld_o     = (state == ST_NOTIFY);
    assign fifo_byte_o    = fifo_vld_o ? NOTIFY_CODE : '0;
    assign frozen_o       = (state == ST_FROZEN);
    assign exit_o         = (state == ST_WAKE);
    assign sram_keep_o    = cap_retain && (state == ST_PDOWN || state == ST_FROZEN);
    assign sram_invalid_o = exit_o && !cap_retain;

    AST_QUIET_WHILE_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_vld_o |-> (pd_strobe_o == '0 && pd_hold_o == '0))
        else $error("power-down during notify"); // R2

    AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_strobe_o != '0) |-> $past(fifo_vld_o && fifo_rdy_i))
        else $error("strobe without accepted byte"); // R4

    AST_EXIT_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |-> $past(frozen_o && wake_i))
        else $error("exit without wake in frozen"); // R6

    AST_EXIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |=> (pd_hold_o == '0 && !exit_o && !busy_o))
        else $error("holds not released after exit"); // R6

    AST_INVALID_WITH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        sram_invalid_o |-> (exit_o && !$past(sram_keep_o)))
        else $error("sram invalid outside sleep exit"); // R7

endmodule

// File: tb/lpf_seq_tb_top.sv
module lpf_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [3:0] req_mask_i = '0;
    logic       retain_i = 1'b0;
    logic       fifo_rdy_i = 1'b0;
    logic       wake_i = 1'b0;
    logic       fifo_vld_o;
    logic [7:0] fifo_byte_o;
    logic [3:0] pd_strobe_o;
    logic [3:0] pd_hold_o;
    logic       req_abort_o;
    logic       busy_o;
    logic       frozen_o;
    logic       exit_o;
    logic       sram_keep_o;
    logic       sram_invalid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpf_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_i),
        .req_mask_i     (req_mask_i),
        .retain_i       (retain_i),
        .fifo_rdy_i     (fifo_rdy_i),
        .wake_i         (wake_i),
        .fifo_vld_o     (fifo_vld_o),
        .fifo_byte_o    (fifo_byte_o),
        .pd_strobe_o    (pd_strobe_o),
        .pd_hold_o      (pd_hold_o),
        .req_abort_o    (req_abort_o),
        .busy_o         (busy_o),
        .frozen_o       (frozen_o),
        .exit_o         (exit_o),
        .sram_keep_o    (sram_keep_o),
        .sram_invalid_o (sram_invalid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [31:0] all_outs();
        return {fifo_vld_o, fifo_byte_o, pd_strobe_o, pd_hold_o, req_abort_o,
                busy_o, frozen_o, exit_o, sram_keep_o, sram_invalid_o};
    endfunction

    task automatic run_service(input logic [3:0] m, input logic ret, input int stall);
        req_i = 1'b1; req_mask_i = m; retain_i = ret;
        step();
        req_i = 1'b0; req_mask_i = ~m; retain_i = ~ret;
        chk("R2 vld", fifo_vld_o, 1);
        chk("R2 byte", fifo_byte_o, 8'hE0);
        chk("R2 no strobe", pd_strobe_o, 0);
        chk("R3 no abort from idle", req_abort_o, 0);
        for (int s = 0; s < stall; s++) begin
            if (s == 0) req_i = 1'b1;
            wake_i = 1'b1;
            step();
            req_i = 1'b0; wake_i = 1'b0;
            chk("R2 stall vld", fifo_vld_o, 1);
            chk("R8 wake ignored in notify", {exit_o, frozen_o}, 0);
            chk("R2 stall strobe", pd_strobe_o, 0);
            if (s == 0) chk("R3 abort in notify", req_abort_o, 1);
        end
        fifo_rdy_i = 1'b1;
        step();
        fifo_rdy_i = 1'b0;
        chk("R4 strobe", pd_strobe_o, m);
        chk("R4 hold not yet", pd_hold_o, 0);
        chk("R7 keep in strobe", sram_keep_o, ret);
        chk("R2 vld dropped", fifo_vld_o, 0);
        req_i = 1'b1; fifo_rdy_i = 1'b1;
        step();
        req_i = 1'b0; fifo_rdy_i = 1'b0;
        chk("R4 strobe one cycle", pd_strobe_o, 0);
        chk("R5 hold", pd_hold_o, m);
        chk("R5 frozen", frozen_o, 1);
        chk("R7 keep frozen", sram_keep_o, ret);
        chk("R3 abort in pdown", req_abort_o, 1);
        step();
        chk("R8 rdy ignored in frozen", {fifo_vld_o, frozen_o, pd_hold_o}, {1'b0, 1'b1, m});
        chk("R3 abort one cycle", req_abort_o, 0);
        wake_i = 1'b1;
        step();
        wake_i = 1'b0;
        chk("R6 exit", exit_o, 1);
        chk("R6 hold during exit", pd_hold_o, m);
        chk("R7 invalid", sram_invalid_o, !ret);
        chk("R7 keep off at exit", sram_keep_o, 0);
        step();
        chk("R6 back idle", {busy_o, exit_o, sram_invalid_o, pd_hold_o}, 0);
    endtask

    initial begin
        repeat (3) step();
        chk("R1 reset outputs", all_outs(), 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle after reset", all_outs(), 0);
        wake_i = 1'b1; fifo_rdy_i = 1'b1;
        step();
        wake_i = 1'b0; fifo_rdy_i = 1'b0;
        chk("R8 idle ignores wake and rdy", all_outs(), 0);

        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 16; m++) begin
                run_service(m[3:0], r[0], (m + r) % 3);
            end
        end

        req_i = 1'b1; req_mask_i = 4'b1010; retain_i = 1'b1;
        step();
        req_i = 1'b0;
        fifo_rdy_i = 1'b1;
        step();
        fifo_rdy_i = 1'b0;
        step();
        chk("R9 frozen before reset", frozen_o, 1);
        rst_n = 1'b0;
        step();
        chk("R9 reset clears freeze", {frozen_o, busy_o, pd_hold_o, sram_keep_o}, 0);
        rst_n = 1'b1;
        step();
        chk("R9 idle after reset", all_outs(), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule